// File: doc/BRIEF.md
# Periodic Wake-up Interrupt Timer

This block raises an interrupt at a fixed, software-chosen interval. It counts ticks from one of two tick-enable inputs: an always-running autonomous tick, or a bus-clock tick. It counts the number of ticks given by a period register plus one, then sets a sticky flag and starts the next interval by itself. Software configures the block through a small register interface. It picks the tick source and the period while the timer is stopped, sets the run bit, and then serves the interrupt by writing 1 to the flag.

While the timer runs, the source and period settings are locked, and writes to them are dropped. When the bus tick is selected and the bus clock is reported as gated off, the count holds where it is. A trim field for the external oscillator is kept and can be read back, but it has no effect on counting.

Top module: `periodic_irq_timer`

## Requirements
- R1: Writing 1 to the run bit (CTRL bit 0, address 0) starts the count from zero. The flag (CTRL bit 8) becomes 1 on the clock edge that counts the (PERIOD+1)-th selected tick, and not before.
- R2: The source-select bit (CTRL bit 1: 0 = autonomous tick, 1 = bus tick) takes a write only while the run bit is 0. A write made while the timer runs leaves the bit unchanged.
- R3: The period register (address 1) takes a write only while the run bit is 0. While the timer runs, a write leaves both the readback and the interval unchanged.
- R4: After each expiry the counter starts the next interval by itself, and the next expiry comes after another PERIOD+1 ticks with no software action.
- R5: `irq` is 1 exactly when the flag is 1 and the interrupt-enable bit (CTRL bit 2) is 1.
- R6: With the bus tick selected, a bus tick seen while `busClkOn` is 0 does not advance the count, and the count is held.
- R7: The trim field (address 2) stores the low TRIM_W bits written and reads them back with zeros above. Its value does not change the interval.
- R8: Writing 0 to the run bit stops the counter and resets it to zero, and a pending flag stays set. After a restart, the full PERIOD+1 ticks are needed again.
- R9: Writing a CTRL word with bit 8 set clears the flag. If an expiry falls on the same edge, the flag stays 1.
- R10: Only the selected source counts. Bus ticks are ignored when the autonomous tick is selected, and autonomous ticks are ignored when the bus tick is selected.
- R11: After reset, CTRL, PERIOD and TRIM read 0, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| autoTick | input | 1 | Tick enable from the autonomous clock domain (synchronised) |
| busTick | input | 1 | Tick enable derived from the bus clock |
| busClkOn | input | 1 | 1 while the bus clock runs, 0 while it is gated |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 CTRL, 1 PERIOD, 2 TRIM |
| wrData | input | DATA_W | Write data |
| rdAddr | input | 2 | Read address, same map |
| rdData | output | DATA_W | Read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with PERIOD_W = 4, so it can sweep all sixteen periods with both tick sources. For every setting it checks the exact tick on which the first expiry and the automatic second expiry fall. Between the counted ticks it inserts idle cycles that pulse the source that is not selected, or pulse a bus tick while the bus clock is gated, so the source selection and the freeze are checked in every run. Separate sequences cover the lock on writes while running, stop-and-restart with a pending flag, and a flag clear that lands on an expiry edge.

// File: rtl/api_pkg.sv
package api_pkg;
  // register addresses
  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_PERIOD = 2'd1;
  localparam logic [1:0] ADDR_TRIM   = 2'd2;

  // CTRL bit positions
  localparam int BIT_RUN   = 0;
  localparam int BIT_SRC   = 1;
  localparam int BIT_IE    = 2;
  localparam int BIT_FLAG  = 8;

  // control -> datapath strobes
  typedef struct packed {
    logic advance;  // count one selected tick
    logic restart;  // hold counter at zero
  } tmrStrobe_t;
endpackage

// File: rtl/api_ctrl.sv
module api_ctrl
  import api_pkg::*;
#(
  parameter int PERIOD_W = 16,
  parameter int TRIM_W   = 6,
  parameter int DATA_W   = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                autoTick,
  input  logic                busTick,
  input  logic                busClkOn,
  input  logic                wrEn,
  input  logic [1:0]          wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [1:0]          rdAddr,
  input  logic                expire,
  output logic [DATA_W-1:0]   rdData,
  output tmrStrobe_t          strobe,
  output logic [PERIOD_W-1:0] periodQ,
  output logic                runQ,
  output logic                srcQ,
  output logic                flagQ,
  output logic                irqEnQ,
  output logic                irq
);
  logic [TRIM_W-1:0] trimQ;
  logic ctrlWr, periodWr, trimWr, selTick, flagClr;

  assign ctrlWr   = wrEn && (wrAddr == ADDR_CTRL);
  assign periodWr = wrEn && (wrAddr == ADDR_PERIOD);
  assign trimWr   = wrEn && (wrAddr == ADDR_TRIM);
  assign flagClr  = ctrlWr && wrData[BIT_FLAG];

  // bus tick only counts while the bus clock runs
  assign selTick = srcQ ? (busTick && busClkOn) : autoTick;

  always_comb begin
    strobe.restart = !runQ;
    strobe.advance = runQ && selTick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ    <= 1'b0;
      srcQ    <= 1'b0;
      irqEnQ  <= 1'b0;
      periodQ <= '0;
      trimQ   <= '0;
    end else begin
      if (ctrlWr) begin
        runQ   <= wrData[BIT_RUN];
        irqEnQ <= wrData[BIT_IE];
        if (!runQ) srcQ <= wrData[BIT_SRC];
      end
      if (periodWr && !runQ) periodQ <= wrData[PERIOD_W-1:0];
      if (trimWr) trimQ <= wrData[TRIM_W-1:0];
    end
  end

  // sticky flag: expiry has priority over a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        flagQ <= 1'b0;
    else if (expire)  flagQ <= 1'b1;
    else if (flagClr) flagQ <= 1'b0;
  end

  assign irq = flagQ && irqEnQ;

  always_comb begin
    rdData = '0;
    unique case (rdAddr)
      ADDR_CTRL: begin
        rdData[BIT_RUN]  = runQ;
        rdData[BIT_SRC]  = srcQ;
        rdData[BIT_IE]   = irqEnQ;
        rdData[BIT_FLAG] = flagQ;
      end
      ADDR_PERIOD: rdData[PERIOD_W-1:0] = periodQ;
      ADDR_TRIM:   rdData[TRIM_W-1:0]   = trimQ;
      default:     rdData = '0;
    endcase
  end
endmodule

// File: rtl/api_count.sv
module api_count
  import api_pkg::*;
#(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  tmrStrobe_t          strobe,
  input  logic [PERIOD_W-1:0] period,
  output logic [PERIOD_W-1:0] cnt,
  output logic                expire
);
  logic atEnd;
  assign atEnd  = (cnt == period);
  assign expire = strobe.advance && atEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= '0;
    else if (strobe.restart) cnt <= '0;
    else if (strobe.advance) cnt <= atEnd ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/periodic_irq_timer.sv
module periodic_irq_timer
  import api_pkg::*;
#(
  parameter int PERIOD_W = 16,
  parameter int TRIM_W   = 6,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              autoTick,
  input  logic              busTick,
  input  logic              busClkOn,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  tmrStrobe_t          strobe;
  logic [PERIOD_W-1:0] periodQ, cnt;
  logic                runQ, srcQ, flagQ, irqEnQ, expire;

  api_ctrl #(.PERIOD_W(PERIOD_W), .TRIM_W(TRIM_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .autoTick(autoTick), .busTick(busTick),
    .busClkOn(busClkOn), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .expire(expire), .rdData(rdData), .strobe(strobe),
    .periodQ(periodQ), .runQ(runQ), .srcQ(srcQ), .flagQ(flagQ),
    .irqEnQ(irqEnQ), .irq(irq)
  );

  api_count #(.PERIOD_W(PERIOD_W)) u_count (
    .clk(clk), .rstN(rstN), .strobe(strobe), .period(periodQ),
    .cnt(cnt), .expire(expire)
  );
endmodule

// File: rtl/api_checker.sv
module api_checker #(
  parameter int PERIOD_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                runQ,
  input logic                srcQ,
  input logic                busClkOn,
  input logic [PERIOD_W-1:0] periodQ,
  input logic [PERIOD_W-1:0] cnt,
  input logic                expire,
  input logic                flagQ,
  input logic                irqEnQ,
  input logic                irq
);
  AST_SRC_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    runQ |=> $stable(srcQ));                                          // R2
  AST_PERIOD_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    runQ |=> $stable(periodQ));                                       // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    runQ |-> cnt <= periodQ);                                         // R4
  AST_EXPIRE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> flagQ);                                                // R9
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (flagQ && irqEnQ));                                       // R5
  AST_BUS_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && srcQ && !busClkOn) |=> $stable(cnt));                    // R6
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !runQ |=> (cnt == '0));                                           // R8
endmodule

bind periodic_irq_timer api_checker #(.PERIOD_W(PERIOD_W)) u_chk (
  .clk(clk), .rstN(rstN), .runQ(runQ), .srcQ(srcQ), .busClkOn(busClkOn),
  .periodQ(periodQ), .cnt(cnt), .expire(expire), .flagQ(flagQ),
  .irqEnQ(irqEnQ), .irq(irq)
);

// File: tb/sim_periodic_irq_timer.sv
module sim_periodic_irq_timer;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 4;
  localparam int DW = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic autoTick = 0, busTick = 0, busClkOn = 1, wrEn = 0;
  logic [1:0] wrAddr = 0, rdAddr = 0;
  logic [DW-1:0] wrData = 0, rdData;
  logic irq;
  int nChk = 0, nErr = 0;
  logic [DW-1:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  periodic_irq_timer #(.PERIOD_W(PW), .TRIM_W(6), .DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .autoTick(autoTick), .busTick(busTick),
    .busClkOn(busClkOn), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .irq(irq)
  );

  function automatic logic [DW-1:0] ctrlWord(logic run, logic src, logic ie, logic clr);
    ctrlWord = '0;
    ctrlWord[0] = run; ctrlWord[1] = src; ctrlWord[2] = ie; ctrlWord[8] = clr;
  endfunction

  task automatic cycle();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic writeReg(logic [1:0] a, logic [DW-1:0] d);
    wrEn = 1; wrAddr = a; wrData = d;
    cycle();
    wrEn = 0;
  endtask

  task automatic readReg(logic [1:0] a, output logic [DW-1:0] d);
    rdAddr = a; #1; d = rdData;
  endtask

  // n selected ticks, each followed by a distractor cycle (R6, R10)
  task automatic ticks(int n, logic src);
    for (int i = 0; i < n; i++) begin
      autoTick = 1; busTick = 1; busClkOn = 1;
      if (src) autoTick = 0;
      cycle();
      autoTick = src; busTick = 1; busClkOn = !src;
      if (!src) busTick = 1;
      cycle();
      autoTick = 0; busTick = 0; busClkOn = 1;
    end
  endtask

  task automatic oneTick(logic src);
    autoTick = !src; busTick = src; busClkOn = 1;
    cycle();
    autoTick = 0; busTick = 0;
  endtask

  initial begin
    repeat (3) cycle();
    rstN = 1;
    cycle();
    // R11 reset state
    readReg(0, rv); check("R11 ctrl", rv, 0);
    readReg(1, rv); check("R11 period", rv, 0);
    readReg(2, rv); check("R11 trim", rv, 0);
    check("R11 irq", {15'b0, irq}, 0);

    // R7 trim storage, truncated to 6 bits
    writeReg(2, 16'h002A); readReg(2, rv); check("R7 trim", rv, 16'h002A);
    writeReg(2, 16'hFFFF); readReg(2, rv); check("R7 trim width", rv, 16'h003F);

    // sweep every period on both sources (trim left at 0x3F: R7 no effect)
    for (int s = 0; s < 2; s++) begin
      for (int p = 0; p < (1 << PW); p++) begin
        writeReg(0, ctrlWord(0, s[0], 1, 1));
        writeReg(1, DW'(p));
        writeReg(0, ctrlWord(1, s[0], 1, 0));
        ticks(p, s[0]);
        check("R1/R6/R10 no early expiry", {15'b0, irq}, 0);
        ticks(1, s[0]);
        check("R1/R5 expiry irq", {15'b0, irq}, 1);
        writeReg(0, ctrlWord(1, s[0], 1, 1));
        check("R9 clear", {15'b0, irq}, 0);
        ticks(p, s[0]);
        check("R4 not yet", {15'b0, irq}, 0);
        ticks(1, s[0]);
        check("R4 auto restart", {15'b0, irq}, 1);
      end
    end

    // R5 irq gated by enable; R2/R3 lock while running
    writeReg(0, ctrlWord(0, 0, 0, 1));
    writeReg(1, 16'd3);
    writeReg(0, ctrlWord(1, 0, 0, 0));
    writeReg(1, 16'd9);                       // R3 ignored
    writeReg(0, ctrlWord(1, 1, 0, 0));        // R2 src change ignored
    readReg(0, rv); check("R2 src locked", rv, ctrlWord(1, 0, 0, 0));
    readReg(1, rv); check("R3 period locked", rv, 16'd3);
    repeat (3) oneTick(0);
    readReg(0, rv); check("R3 interval unchanged pre", rv[8], 0);
    oneTick(0);
    readReg(0, rv); check("R3 interval unchanged", rv[8], 1);
    check("R5 irq masked", {15'b0, irq}, 0);
    writeReg(0, ctrlWord(1, 0, 1, 0));
    check("R5 irq enabled", {15'b0, irq}, 1);

    // R8 stop keeps flag and resets count
    repeat (2) oneTick(0);
    writeReg(0, ctrlWord(0, 0, 1, 0));
    readReg(0, rv); check("R8 flag kept", rv, ctrlWord(0, 0, 1, 1));
    writeReg(0, ctrlWord(1, 0, 1, 1));
    repeat (3) oneTick(0);
    readReg(0, rv); check("R8 full interval after restart", rv[8], 0);
    oneTick(0);
    readReg(0, rv); check("R8 expiry after restart", rv[8], 1);

    // R9 clear on the same edge as an expiry: flag stays
    repeat (3) oneTick(0);
    autoTick = 1; wrEn = 1; wrAddr = 0; wrData = ctrlWord(1, 0, 1, 1);
    cycle();
    autoTick = 0; wrEn = 0;
    readReg(0, rv); check("R9 expiry wins", rv[8], 1);
    writeReg(0, ctrlWord(0, 0, 1, 1));
    readReg(0, rv); check("R9 plain clear", rv[8], 0);

    // R2/R3 writable again when stopped
    writeReg(0, ctrlWord(0, 1, 0, 0));
    writeReg(1, 16'd7);
    readReg(0, rv); check("R2 src writable stopped", rv[1], 1);
    readReg(1, rv); check("R3 period writable stopped", rv, 16'd7);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end
endmodule